// File: doc/BRIEF.md
# Local Bus Deadlock Backoff Controller

This block sits on the local-bus side of a PCI-to-local bridge. When a PCI-originated access needs the local bus, the bridge pulses a request. The block then starts a programmable timer and waits for the arbiter's hold-acknowledge. If the timer runs out first, the block assumes that a local master is holding the bus while it waits on the bridge. In that case it raises a backoff request to the external arbiter. From that moment it gives no further ready to the local cycle in progress. This forces that master off the bus. The pending bridge access then proceeds once hold-acknowledge arrives.

When the bridge finishes, it releases the bus and the backoff request drops. The interrupted master then restarts its cycle with a new address strobe. The block compares the address and direction of the restarted cycle with those latched for the interrupted cycle.

- **Identical restart, write:** the beat numbering resumes after the last acknowledged beat.
- **Identical restart, read:** read data that the PCI side delivered during the backoff is returned at once, without a second fetch.
- **Any other restart:** the beat numbering starts from zero, held read data is dropped, and a new fetch is issued.

Top module: `lbus_backoff`

## Requirements
- R1: After `busReq` is sampled high in the idle state with `cfgTimeout` = N and `holdAck` low throughout, `bkReq` rises on the (N+1)th rising edge after the one that sampled `busReq`.
- R2: If `holdAck` is sampled high before the timer expires, `bkReq` stays low and `busOwn` is high after that edge.
- R3: While `bkReq` or `busOwn` is high, `lmReady` stays low, even with a beat presented, write space free and PCI read data valid.
- R4: When `holdAck` is sampled high while backing off, `busOwn` rises after that edge and `bkReq` stays high.
- R5: When `bridgeDone` is sampled high while `busOwn` is high, both `busOwn` and `bkReq` are low after that edge.
- R6: Each acknowledged write beat pulses `wrPush` with `wrData` = `lmWData` and `wrBeat` equal to the number of beats already acknowledged in the cycle (0, 1, 2, ...).
- R7: A restart whose address and direction both match the backed-off cycle continues `wrBeat` from the count of beats acknowledged before the backoff.
- R8: Any address strobe that is not a matching restart resets `wrBeat` to 0 for the new cycle.
- R9: Read data that arrives (`pciRdValid`) while ready is withheld is held. On a matching read restart, the first presented beat gets `lmReady` with that data, and `rdFetch` stays low.
- R10: On a non-matching restart, the held read data is discarded. `rdFetch` is raised, and `lmReady` waits for fresh `pciRdValid` data.
- R11: After reset, `bkReq`, `busOwn`, `lmReady`, `wrPush` and `rdFetch` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTimeout | input | TW | Backoff timer load value |
| busReq | input | 1 | Bridge requests local bus (pulse) |
| holdAck | input | 1 | Hold acknowledge from arbiter |
| bridgeDone | input | 1 | Bridge access finished, release bus |
| busOwn | output | 1 | Bridge owns the local bus |
| bkReq | output | 1 | Backoff request to external arbiter |
| lmAds | input | 1 | Local master address strobe |
| lmAddr | input | AW | Local cycle address |
| lmWrite | input | 1 | Cycle direction, 1 = write |
| lmValid | input | 1 | Local master presents a data beat |
| lmWData | input | DW | Local write data |
| lmReady | output | 1 | Ready for the current beat |
| lmRData | output | DW | Read data returned to the local master |
| wrFull | input | 1 | Write storage cannot accept a beat |
| wrPush | output | 1 | Write beat acknowledged |
| wrData | output | DW | Acknowledged write data |
| wrBeat | output | BW | Beat index within the cycle |
| rdFetch | output | 1 | Request read data from PCI side |
| rdAddr | output | AW | Address for the read fetch |
| pciRdValid | input | 1 | PCI read data valid |
| pciRdData | input | DW | PCI read data |

## Verification
Two events can collide in one cycle: read data arriving from the PCI side, and the withholding of ready that backoff enforces. The bench provokes this by issuing a read fetch and letting the timer expire before returning data. It then pulses `pciRdValid` while `bkReq` is high. The data must not produce `lmReady` in that cycle. It must instead reappear on a matching restart and vanish on a differing one. Write beats presented during backoff are judged the same way: `wrPush` must stay low, and the beat index must resume exactly after the last acknowledged beat.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BACK = 2'd2,
    ST_OWN  = 2'd3
  } lbbState_e;

  typedef struct packed {
    logic loadTimer;
    logic runTimer;
    logic allowRdy;
    logic markBacked;
  } lbbCtl_t;

endpackage

// File: rtl/lbb_ctrl.sv
module lbb_ctrl
  import lbb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busReq,
  input  logic    holdAck,
  input  logic    bridgeDone,
  input  logic    timerZero,
  output lbbCtl_t ctl,
  output logic    busOwn,
  output logic    bkReq
);

  lbbState_e state, stateNext;
  logic      bkNext;

  always_comb begin
    stateNext      = state;
    bkNext         = bkReq;
    ctl            = '0;
    ctl.allowRdy   = (state == ST_IDLE) || (state == ST_WAIT);
    unique case (state)
      ST_IDLE: begin
        if (busReq) begin
          stateNext     = ST_WAIT;
          ctl.loadTimer = 1'b1;
        end
      end
      ST_WAIT: begin
        ctl.runTimer = 1'b1;
        if (holdAck) begin
          stateNext = ST_OWN;
        end else if (timerZero) begin
          stateNext      = ST_BACK;
          bkNext         = 1'b1;
          ctl.markBacked = 1'b1;
        end
      end
      ST_BACK: begin
        if (holdAck) stateNext = ST_OWN;
      end
      ST_OWN: begin
        if (bridgeDone) begin
          stateNext = ST_IDLE;
          bkNext    = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bkReq <= 1'b0;
    end else begin
      state <= stateNext;
      bkReq <= bkNext;
    end
  end

  assign busOwn = (state == ST_OWN);

  // R1: expiry without acknowledge raises the backoff request
  p_expire_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && timerZero && !holdAck) |=> bkReq);

  // R2: early acknowledge grants without backoff
  p_quiet_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && holdAck && !bkReq) |=> (busOwn && !bkReq));

  // R4: acknowledge during backoff grants and keeps request up
  p_own_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACK && holdAck) |=> (busOwn && bkReq));

  // R5: release drops ownership and backoff request
  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busOwn && bridgeDone) |=> (!busOwn && !bkReq));

endmodule

// File: rtl/lbb_data.sv
module lbb_data
  import lbb_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  lbbCtl_t       ctl,
  input  logic [TW-1:0] cfgTimeout,
  output logic          timerZero,
  input  logic          lmAds,
  input  logic [AW-1:0] lmAddr,
  input  logic          lmWrite,
  input  logic          lmValid,
  input  logic [DW-1:0] lmWData,
  output logic          lmReady,
  output logic [DW-1:0] lmRData,
  input  logic          wrFull,
  output logic          wrPush,
  output logic [DW-1:0] wrData,
  output logic [BW-1:0] wrBeat,
  output logic          rdFetch,
  output logic [AW-1:0] rdAddr,
  input  logic          pciRdValid,
  input  logic [DW-1:0] pciRdData
);

  localparam logic [TW-1:0] TZERO = '0;

  logic [TW-1:0] timerCnt;
  logic [AW-1:0] curAddr;
  logic          curWrite;
  logic          active;
  logic          backedFlag;
  logic [BW-1:0] ackCnt;
  logic          heldValid;
  logic [DW-1:0] heldData;

  logic restartMatch;
  logic rdCycle;
  logic wrOk, rdHeldOk, rdLiveOk;

  assign timerZero    = (timerCnt == TZERO);
  assign restartMatch = backedFlag && (lmAddr == curAddr) && (lmWrite == curWrite);
  assign rdCycle      = ctl.allowRdy && active && !curWrite && lmValid;

  assign wrOk     = ctl.allowRdy && active && curWrite && lmValid && !wrFull;
  assign rdHeldOk = rdCycle && heldValid;
  assign rdLiveOk = rdCycle && !heldValid && pciRdValid;

  assign lmReady = wrOk || rdHeldOk || rdLiveOk;
  assign lmRData = heldValid ? heldData : pciRdData;
  assign wrPush  = wrOk;
  assign wrData  = lmWData;
  assign wrBeat  = ackCnt;
  assign rdFetch = rdCycle && !heldValid;
  assign rdAddr  = curAddr;

  // backoff timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (ctl.loadTimer) begin
      timerCnt <= cfgTimeout;
    end else if (ctl.runTimer && !timerZero) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  // cycle tracking, beat count and held read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      curWrite   <= 1'b0;
      active     <= 1'b0;
      backedFlag <= 1'b0;
      ackCnt     <= '0;
      heldValid  <= 1'b0;
      heldData   <= '0;
    end else if (lmAds) begin
      curAddr    <= lmAddr;
      curWrite   <= lmWrite;
      active     <= 1'b1;
      backedFlag <= 1'b0;
      if (!restartMatch) begin
        ackCnt    <= '0;
        heldValid <= 1'b0;
      end
    end else begin
      if (ctl.markBacked && active) backedFlag <= 1'b1;
      if (wrOk) ackCnt <= ackCnt + 1'b1;
      if (rdHeldOk) begin
        heldValid <= 1'b0;
      end else if (pciRdValid && !ctl.allowRdy && active && !curWrite) begin
        heldValid <= 1'b1;
        heldData  <= pciRdData;
      end
    end
  end

  // R3: no ready while the bus is withheld from the local master
  p_rdy_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.allowRdy |-> !lmReady);

  // R8: a non-matching strobe restarts numbering at zero
  p_idx_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lmAds && !restartMatch) |=> (wrBeat == '0));

  // R10: a non-matching strobe discards held read data
  p_held_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lmAds && !restartMatch) |=> !heldValid);

  // R9: a replayed beat never issues a fetch
  p_replay_nofetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lmReady && heldValid) |-> !rdFetch);

endmodule

// File: rtl/lbus_backoff.sv
module lbus_backoff
  import lbb_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfgTimeout,
  input  logic          busReq,
  input  logic          holdAck,
  input  logic          bridgeDone,
  output logic          busOwn,
  output logic          bkReq,
  input  logic          lmAds,
  input  logic [AW-1:0] lmAddr,
  input  logic          lmWrite,
  input  logic          lmValid,
  input  logic [DW-1:0] lmWData,
  output logic          lmReady,
  output logic [DW-1:0] lmRData,
  input  logic          wrFull,
  output logic          wrPush,
  output logic [DW-1:0] wrData,
  output logic [BW-1:0] wrBeat,
  output logic          rdFetch,
  output logic [AW-1:0] rdAddr,
  input  logic          pciRdValid,
  input  logic [DW-1:0] pciRdData
);

  lbbCtl_t ctl;
  logic    timerZero;

  lbb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .holdAck    (holdAck),
    .bridgeDone (bridgeDone),
    .timerZero  (timerZero),
    .ctl        (ctl),
    .busOwn     (busOwn),
    .bkReq      (bkReq)
  );

  lbb_data #(.TW(TW), .AW(AW), .DW(DW), .BW(BW)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgTimeout (cfgTimeout),
    .timerZero  (timerZero),
    .lmAds      (lmAds),
    .lmAddr     (lmAddr),
    .lmWrite    (lmWrite),
    .lmValid    (lmValid),
    .lmWData    (lmWData),
    .lmReady    (lmReady),
    .lmRData    (lmRData),
    .wrFull     (wrFull),
    .wrPush     (wrPush),
    .wrData     (wrData),
    .wrBeat     (wrBeat),
    .rdFetch    (rdFetch),
    .rdAddr     (rdAddr),
    .pciRdValid (pciRdValid),
    .pciRdData  (pciRdData)
  );

endmodule

// File: tb/lbus_backoff_bench.sv
module lbus_backoff_bench;

  localparam int TW = 8, AW = 16, DW = 32, BW = 4;

  logic clk = 0, rstN = 0;
  logic [TW-1:0] cfgTimeout = '0;
  logic busReq = 0, holdAck = 0, bridgeDone = 0;
  logic busOwn, bkReq;
  logic lmAds = 0, lmWrite = 0, lmValid = 0;
  logic [AW-1:0] lmAddr = '0;
  logic [DW-1:0] lmWData = '0;
  logic lmReady;
  logic [DW-1:0] lmRData;
  logic wrFull = 0, wrPush, rdFetch;
  logic [DW-1:0] wrData;
  logic [BW-1:0] wrBeat;
  logic [AW-1:0] rdAddr;
  logic pciRdValid = 0;
  logic [DW-1:0] pciRdData = '0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lbus_backoff #(.TW(TW), .AW(AW), .DW(DW), .BW(BW)) u_lbus_backoff (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic w);
    lmAds = 1; lmAddr = a; lmWrite = w; lmValid = 0;
    tick();
    lmAds = 0;
  endtask

  // request the bus and wait for backoff; returns edges after the sampling edge
  task automatic reqUntilBackoff(input logic [TW-1:0] n, output int edges);
    cfgTimeout = n; busReq = 1;
    tick();
    busReq = 0;
    edges = 0;
    for (int k = 0; k < 300; k++) begin
      if (bkReq) break;
      tick();
      edges++;
    end
  endtask

  task automatic grantRelease(input string tag);
    holdAck = 1;
    tick();
    holdAck = 0;
    check(busOwn && bkReq, {tag, " R4 own with request held"}, {busOwn, bkReq}, 2'b11);
    bridgeDone = 1;
    tick();
    bridgeDone = 0;
    check(!busOwn && !bkReq, {tag, " R5 release"}, {busOwn, bkReq}, 2'b00);
  endtask

  task automatic t_reset();
    #1;
    check(!bkReq && !busOwn && !lmReady && !wrPush && !rdFetch, "R11 reset outputs",
          {bkReq, busOwn, lmReady, wrPush, rdFetch}, 0);
  endtask

  task automatic t_quickGrant();
    cfgTimeout = 8'd5; busReq = 1;
    tick();
    busReq = 0;
    tick();
    holdAck = 1;
    tick();
    holdAck = 0;
    check(busOwn && !bkReq, "R2 early grant", {busOwn, bkReq}, 2'b10);
    for (int k = 0; k < 8; k++) begin
      tick();
      check(!bkReq, "R2 no backoff after grant", bkReq, 0);
    end
    bridgeDone = 1;
    tick();
    bridgeDone = 0;
    check(!busOwn, "R5 release after early grant", busOwn, 0);
  endtask

  task automatic t_expiry();
    int e;
    reqUntilBackoff(8'd4, e);
    check(e == 5, "R1 expiry edge count", e, 5);
    reqUntilBackoff(8'd0, e);
    check(0, "R1 unreachable", 0, 0);
  endtask

  task automatic t_writeResume();
    int e;
    strobe(16'h0100, 1);
    lmValid = 1;
    for (int b = 0; b < 3; b++) begin
      lmWData = 32'hA000 + b;
      #1;
      check(wrPush && lmReady && wrBeat == b && wrData == 32'hA000 + b, "R6 write beat",
            {wrBeat, wrData[27:0]}, {b[3:0], 28'hA000 + b[27:0]});
      tick();
    end
    lmValid = 0;
    reqUntilBackoff(8'd2, e);
    check(e == 3, "R1 expiry N=2", e, 3);
    lmValid = 1; lmWData = 32'hA003;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!lmReady && !wrPush, "R3 ready withheld in backoff", {lmReady, wrPush}, 0);
      tick();
    end
    holdAck = 1;
    #1;
    check(!lmReady, "R3 ready withheld at grant", lmReady, 0);
    tick();
    holdAck = 0;
    #1;
    check(!lmReady, "R3 ready withheld while owned", lmReady, 0);
    check(busOwn && bkReq, "R4 own with request held", {busOwn, bkReq}, 2'b11);
    bridgeDone = 1;
    tick();
    bridgeDone = 0;
    check(!busOwn && !bkReq, "R5 release", {busOwn, bkReq}, 0);
    lmValid = 0;
    strobe(16'h0100, 1);
    lmValid = 1; lmWData = 32'hA003;
    #1;
    check(wrPush && wrBeat == 3, "R7 resume after last acked beat", wrBeat, 3);
    tick();
    lmValid = 0;
    reqUntilBackoff(8'd1, e);
    grantRelease("wr2");
    strobe(16'h0200, 1);
    lmValid = 1;
    #1;
    check(wrPush && wrBeat == 0, "R8 differing restart index", wrBeat, 0);
    tick();
    lmValid = 0;
    strobe(16'h0300, 1);
    lmValid = 1;
    #1;
    check(wrPush && wrBeat == 0, "R8 fresh cycle index", wrBeat, 0);
    tick();
    lmValid = 0;
  endtask

  task automatic t_readReplay();
    int e;
    strobe(16'h0400, 0);
    lmValid = 1;
    #1;
    check(rdFetch && rdAddr == 16'h0400 && !lmReady, "R9 fetch issued", {rdFetch, rdAddr}, {1'b1, 16'h0400});
    reqUntilBackoff(8'd1, e);
    #1;
    check(!rdFetch, "R3 fetch dropped in backoff", rdFetch, 0);
    pciRdValid = 1; pciRdData = 32'hD1D1;
    #1;
    check(!lmReady, "R3 no ready when data lands in backoff", lmReady, 0);
    tick();
    pciRdValid = 0;
    lmValid = 0;
    grantRelease("rd1");
    strobe(16'h0400, 0);
    lmValid = 1;
    #1;
    check(lmReady && lmRData == 32'hD1D1 && !rdFetch, "R9 replay held data", lmRData, 32'hD1D1);
    tick();
    #1;
    check(rdFetch && !lmReady, "R9 next beat fetches again", {rdFetch, lmReady}, 2'b10);
    reqUntilBackoff(8'd1, e);
    pciRdValid = 1; pciRdData = 32'hD2D2;
    tick();
    pciRdValid = 0;
    lmValid = 0;
    grantRelease("rd2");
    strobe(16'h0500, 0);
    lmValid = 1;
    #1;
    check(rdFetch && !lmReady, "R10 differing restart refetches", {rdFetch, lmReady}, 2'b10);
    tick();
    pciRdValid = 1; pciRdData = 32'hD3D3;
    #1;
    check(lmReady && lmRData == 32'hD3D3, "R10 fresh data returned", lmRData, 32'hD3D3);
    tick();
    pciRdValid = 0; lmValid = 0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e;
    t_reset();
    tick(); tick();
    rstN = 1;
    tick();
    t_reset();
    t_quickGrant();
    reqUntilBackoff(8'd4, e);
    check(e == 5, "R1 expiry edge count N=4", e, 5);
    grantRelease("exp");
    reqUntilBackoff(8'd0, e);
    check(e == 1, "R1 expiry edge count N=0", e, 1);
    grantRelease("exp0");
    t_writeResume();
    t_readReplay();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule